// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with One-Hot Operation Select

This block is a 32-bit integer arithmetic and logic unit. It is built from a row of identical one-bit slices. A 3-bit command chooses one of eight operations: add, subtract, signed set-less-than, and five bitwise functions. The command is decoded once, at the top, into a one-hot select word. Every slice receives that word and picks its own output bit with an AND-OR multiplexer, so no slice carries a decoder.

The slices share one ripple chain from bit 0 upward, and three operations use it:
- Addition uses it as an ordinary carry chain, with a carry-in of 0.
- Subtraction inverts B inside each slice and forces the carry-in of bit 0 to 1.
- Set-less-than uses the chain as a magnitude comparator. Each slice passes its incoming value through when its two operand bits match. When they differ, it replaces that value with a decision. The top takes the chain's final output and inverts it when the operand signs differ.

The unit produces a result word and three flags: carry-out, signed overflow and zero. The result and flags are captured in an output register, so they appear one clock after the operands and command. A synchronous active-high reset clears that register.

Top module: `slice_alu`

## Requirements
- R1: With command 000 (add), the result one cycle later is A+B modulo 2^32, and carry_out is bit 32 of the unsigned sum.
- R2: With command 001 (subtract), the result one cycle later is A-B modulo 2^32. It is formed as A + ~B + 1, and carry_out is the carry out of that sum, which is 1 exactly when A >= B as unsigned values.
- R3: overflow is 1 for add (000) when A and B have the same sign and the result sign differs from it. It is 1 for subtract (001) when A and B have different signs and the result sign differs from A's sign. Otherwise it is 0.
- R4: With command 011 (set-less-than), result bit 0 is 1 exactly when A < B as signed two's-complement values, and result bits 31..1 are 0. Equal operands give 0, and this includes the most negative value compared with itself.
- R5: Commands 010, 100, 101, 110 and 111 give, bit by bit, A XOR B, A AND B, NOT(A AND B), NOT(A OR B) and A OR B respectively.
- R6: For every command other than 000 and 001, carry_out and overflow are 0.
- R7: zero is 1 exactly when all 32 bits of the registered result are 0, for every command.
- R8: All outputs are registered, with one cycle of latency. While rst is high at a rising edge, the outputs become result=0, carry_out=0, overflow=0 and zero=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; outputs update on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the output register |
| cmd | input | 3 | Operation code (encodings listed in the requirements) |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| result | output | 32 | Registered operation result |
| carry_out | output | 1 | Final carry of add/subtract, 0 otherwise |
| overflow | output | 1 | Signed overflow of add/subtract, 0 otherwise |
| zero | output | 1 | High when the registered result is all zeros |

## Verification
The directed vectors exercise the arithmetic boundaries, which separate carry from signed overflow:
- the largest positive value plus one;
- two most-negative values added together;
- all-ones plus one, which gives a zero result with a carry;
- subtraction of equal values;
- subtraction across the sign boundary in both directions.

Set-less-than is tried on every pairing of operand signs, on equal operands, and on the most negative value against zero and against itself. These cases show whether the comparison chain and the sign fix-up are each correct: a chain without the fix-up gives the wrong answer exactly when the signs differ. Pseudo-random operands for all eight commands are then compared against an arithmetic reference model. They check the bitwise paths, the one-hot selection and the quiet flags of the non-arithmetic commands.

// File: rtl/salu_pkg.sv
package salu_pkg;
  localparam int CMD_W    = 3;
  localparam int OP_COUNT = 1 << CMD_W;

  typedef enum logic [CMD_W-1:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_XOR  = 3'd2,
    OP_SLT  = 3'd3,
    OP_AND  = 3'd4,
    OP_NAND = 3'd5,
    OP_NOR  = 3'd6,
    OP_OR   = 3'd7
  } op_e;

  typedef logic [OP_COUNT-1:0] op_sel_t;
endpackage

// File: rtl/salu_cmd_decode.sv
module salu_cmd_decode
  import salu_pkg::*;
(
  input  logic [CMD_W-1:0] cmd,
  output op_sel_t          sel
);
  for (genvar i = 0; i < OP_COUNT; i++) begin : g_line
    assign sel[i] = (cmd == CMD_W'(i));
  end
endmodule

// File: rtl/salu_slice.sv
module salu_slice
  import salu_pkg::*;
(
  input  logic    a,
  input  logic    b,
  input  logic    cin,
  input  op_sel_t sel,
  output logic    res,
  output logic    cout
);
  logic    b_eff;
  logic    sum;
  logic    add_c;
  logic    cmp_c;
  op_sel_t cand;

  // B is inverted for subtract; the carry into bit 0 supplies the +1
  assign b_eff = b ^ sel[OP_SUB];
  assign sum   = a ^ b_eff ^ cin;
  assign add_c = (a & b_eff) | (cin & (a ^ b_eff));

  // comparison: equal bits forward the lower verdict, differing bits decide
  assign cmp_c = (a == b) ? cin : (~a & b);

  assign cout  = sel[OP_SLT] ? cmp_c : add_c;

  always_comb begin
    cand          = '0;
    cand[OP_ADD]  = sum;
    cand[OP_SUB]  = sum;
    cand[OP_XOR]  = a ^ b;
    cand[OP_SLT]  = 1'b0;
    cand[OP_AND]  = a & b;
    cand[OP_NAND] = ~(a & b);
    cand[OP_NOR]  = ~(a | b);
    cand[OP_OR]   = a | b;
  end

  // one-hot AND-OR multiplexer
  assign res = |(sel & cand);
endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import salu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CMD_W-1:0] cmd,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             overflow,
  output logic             zero
);
  localparam int MSB = WIDTH - 1;

  op_sel_t          sel;
  logic [WIDTH:0]   chain;
  logic [WIDTH-1:0] slice_res;
  logic [WIDTH-1:0] res_d;
  logic             arith;
  logic             signs_differ;
  logic             less;
  logic             ovf_d;

  salu_cmd_decode u_dec (
    .cmd (cmd),
    .sel (sel)
  );

  // subtract needs a carry-in of 1; add and set-less-than start from 0
  assign chain[0] = sel[OP_SUB];

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    salu_slice u_slice (
      .a    (op_a[i]),
      .b    (op_b[i]),
      .cin  (chain[i]),
      .sel  (sel),
      .res  (slice_res[i]),
      .cout (chain[i+1])
    );
  end

  assign arith        = sel[OP_ADD] | sel[OP_SUB];
  assign signs_differ = op_a[MSB] ^ op_b[MSB];
  // unsigned verdict from the chain, corrected when the signs differ
  assign less         = chain[WIDTH] ^ signs_differ;

  always_comb begin
    res_d    = slice_res;
    res_d[0] = slice_res[0] | (sel[OP_SLT] & less);
  end

  // the effective B sign must match A's sign and the result's sign must not
  assign ovf_d = arith & (op_a[MSB] == (op_b[MSB] ^ sel[OP_SUB]))
                       & (res_d[MSB] != op_a[MSB]);

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      carry_out <= 1'b0;
      overflow  <= 1'b0;
      zero      <= 1'b1;
    end else begin
      result    <= res_d;
      carry_out <= chain[WIDTH] & arith;
      overflow  <= ovf_d;
      zero      <= ~|res_d;
    end
  end

  // R6: flags stay low for non-arithmetic commands
  assert_quiet_flags_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd != OP_ADD && cmd != OP_SUB) |=> (!carry_out && !overflow));

  // R4: set-less-than drives only bit 0
  assert_slt_upper_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd == OP_SLT) |=> (result[MSB:1] == '0));

  // R4: equal operands are never less
  assert_slt_equal_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd == OP_SLT && op_a == op_b) |=> (result == '0));

  // R2: equal subtraction gives zero with no borrow
  assert_sub_equal_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd == OP_SUB && op_a == op_b) |=> (zero && carry_out && !overflow));

  // R7: identical XOR operands give a zero flag
  assert_xor_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd == OP_XOR && op_a == op_b) |=> zero);

  // R3: adding operands of opposite sign never overflows
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd == OP_ADD && op_a[MSB] != op_b[MSB]) |=> !overflow);
endmodule

// File: tb/slice_alu_tb_top.sv
`timescale 1ns/1ps
module slice_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cmd = '0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [31:0] result;
  logic        carry_out, overflow, zero;

  typedef struct {
    logic [31:0] r;
    logic        c;
    logic        v;
    logic        z;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_vec = 0;
  int          n_bad = 0;
  logic [31:0] seed = 32'h1234_5679;

  always #2 clk = ~clk;

  slice_alu dut_i (
    .clk(clk), .rst(rst), .cmd(cmd), .op_a(op_a), .op_b(op_b),
    .result(result), .carry_out(carry_out), .overflow(overflow), .zero(zero)
  );

  function automatic exp_t model(input logic [2:0] c, input logic [31:0] a,
                                 input logic [31:0] b, input string tag);
    exp_t        e;
    logic [32:0] s;
    e.c = 1'b0; e.v = 1'b0; e.r = '0; e.tag = tag;
    case (c)
      3'd0: begin
        s = {1'b0, a} + {1'b0, b};
        e.r = s[31:0]; e.c = s[32];
        e.v = (a[31] == b[31]) && (e.r[31] != a[31]);
      end
      3'd1: begin
        s = {1'b0, a} + {1'b0, ~b} + 33'd1;
        e.r = s[31:0]; e.c = s[32];
        e.v = (a[31] != b[31]) && (e.r[31] != a[31]);
      end
      3'd2: e.r = a ^ b;
      3'd3: e.r = {31'd0, ($signed(a) < $signed(b))};
      3'd4: e.r = a & b;
      3'd5: e.r = ~(a & b);
      3'd6: e.r = ~(a | b);
      default: e.r = a | b;
    endcase
    e.z = (e.r == 32'd0);
    return e;
  endfunction

  function automatic logic [31:0] next_rand(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic apply(input logic [2:0] c, input logic [31:0] a,
                       input logic [31:0] b, input string tag);
    @(negedge clk);
    cmd = c; op_a = a; op_b = b;
    sb.push_back(model(c, a, b, tag));
  endtask

  // monitor: one registered result per cycle, sampled after the edge
  always @(posedge clk) begin
    #1;
    if (!rst && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_vec++;
      if (result !== e.r || carry_out !== e.c || overflow !== e.v || zero !== e.z) begin
        n_bad++;
        $display("FAIL %s: got r=%h c=%b v=%b z=%b, expected r=%h c=%b v=%b z=%b",
                 e.tag, result, carry_out, overflow, zero, e.r, e.c, e.v, e.z);
      end
    end
  end

  task automatic finish_run;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: got hung run, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    n_vec++; // R8 reset state
    if (result !== 32'd0 || carry_out !== 1'b0 || overflow !== 1'b0 || zero !== 1'b1) begin
      n_bad++;
      $display("FAIL R8: got r=%h c=%b v=%b z=%b, expected r=0 c=0 v=0 z=1",
               result, carry_out, overflow, zero);
    end
    rst = 1'b0;

    // R1 / R3 / R7 add boundaries
    apply(3'd0, 32'h0000_0005, 32'h0000_0007, "R1");
    apply(3'd0, 32'hFFFF_FFFF, 32'h0000_0001, "R1 R7");
    apply(3'd0, 32'h7FFF_FFFF, 32'h0000_0001, "R3");
    apply(3'd0, 32'h8000_0000, 32'h8000_0000, "R3");
    apply(3'd0, 32'h8000_0000, 32'h7FFF_FFFF, "R3");
    // R2 / R3 subtract boundaries
    apply(3'd1, 32'h0000_0005, 32'h0000_0005, "R2 R7");
    apply(3'd1, 32'h0000_0003, 32'h0000_0005, "R2");
    apply(3'd1, 32'h8000_0000, 32'h0000_0001, "R3");
    apply(3'd1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R3");
    apply(3'd1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, "R3");
    // R4 sign combinations and extremes
    apply(3'd3, 32'hFFFF_FFFF, 32'h0000_0001, "R4");
    apply(3'd3, 32'h0000_0001, 32'hFFFF_FFFF, "R4");
    apply(3'd3, 32'hFFFF_FFFB, 32'hFFFF_FFFD, "R4");
    apply(3'd3, 32'hFFFF_FFFD, 32'hFFFF_FFFB, "R4");
    apply(3'd3, 32'h0000_0002, 32'h0000_0009, "R4");
    apply(3'd3, 32'h0000_0009, 32'h0000_0002, "R4");
    apply(3'd3, 32'h0000_0007, 32'h0000_0007, "R4");
    apply(3'd3, 32'h8000_0000, 32'h0000_0000, "R4");
    apply(3'd3, 32'h0000_0000, 32'h8000_0000, "R4");
    apply(3'd3, 32'h8000_0000, 32'h8000_0000, "R4");
    // R5 / R6 bitwise with quiet flags
    apply(3'd2, 32'hF0F0_1234, 32'hFFFF_0000, "R5");
    apply(3'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 R6");
    apply(3'd5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 R7");
    apply(3'd6, 32'h0000_0000, 32'h0000_0000, "R5 R6");
    apply(3'd7, 32'hA5A5_0000, 32'h0000_5A5A, "R5");

    for (int i = 0; i < 2000; i++) begin
      logic [31:0] ra, rb;
      seed = next_rand(seed); ra = seed;
      seed = next_rand(seed); rb = (i % 5 == 0) ? ra : seed;
      apply(3'(i % 8), ra, rb, "R1 R2 R3 R4 R5 R6 R7");
    end

    @(negedge clk);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule